// File: doc/BRIEF.md
# Indirect 16-bit Register Access Bridge

The bridge lets an 8-bit register port with 6-bit addresses reach a bank of 16-bit feature registers. These wide registers have no address of their own on the byte port. To write one, software loads a target index, a low byte and a high byte into three staging registers. It then writes the commit key to a trigger register, and the staged pair is copied in one step into the selected feature register. The same sequence can run again as many times as needed, so any number of feature registers can be programmed one after another.

To read a feature register, software loads the target index into the staging index register. It then reads two byte windows, one giving the low half and one giving the high half of the selected register. Both windows are combinational views of the bank. The word written by a commit can therefore be read in the cycle after the commit edge. The staging registers can also be read back. All other addresses read as zero and ignore writes.

Top module: `ib16_bridge`

## Requirements
- R1: After a synchronous active-high reset, all three staging registers read 0x00 and every feature register holds 0x0000.
- R2: A write to address 0x18 loads the 8-bit feature index. Reading 0x18 returns the stored index.
- R3: A write to 0x19 stages the low byte and a write to 0x1A stages the high byte. Reading either address returns the staged byte.
- R4: Writing exactly 0x01 to address 0x25 stores {byte at 0x1A, byte at 0x19} into the feature register selected by 0x18. The high byte forms bits 15:8 of that register.
- R5: Writing any value other than 0x01 to 0x25 leaves every feature register unchanged.
- R6: Reading 0x1B returns bits 7:0 of the feature register selected by 0x18, and reading 0x1C returns bits 15:8. A new index is reflected without waiting for a commit.
- R7: A committed word is visible through 0x1B/0x1C in the cycle that follows the commit edge.
- R8: Writes to the staging registers alone do not modify the bank. A commit changes only the selected entry, so earlier programmed entries keep their values.
- R9: Addresses with no register read 0x00. Writes to those addresses, and writes to the read-only windows 0x1B and 0x1C, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Byte register address |
| reg_wr | input | 1 | Write strobe for the addressed byte register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register, combinational |

## Verification
The embedded assertions run on every cycle. They check that the staging registers hold their values when no write occurs, that a write loads the index register, that a keyed commit lands in the bank and shows up on the byte windows one cycle later, that a commit without the key leaves the selected word untouched, and that each window carries the correct half of the bank word. Several things only the bench scenarios can show. One is that earlier entries survive later commits to other indices. Others are that writes to the read-only windows and to unmapped addresses change nothing visible, and that reset clears the entire bank. Each of these needs a specific history of writes followed by reads at chosen indices.

// File: rtl/ib16_pkg.sv
package ib16_pkg;

    localparam int REG_AW = 6;
    localparam int BYTE_W = 8;
    localparam int FIDX_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int FDEPTH = 1 << FIDX_W;

    localparam logic [REG_AW-1:0] RA_SEL  = 6'h18;
    localparam logic [REG_AW-1:0] RA_LO   = 6'h19;
    localparam logic [REG_AW-1:0] RA_HI   = 6'h1A;
    localparam logic [REG_AW-1:0] RA_RBLO = 6'h1B;
    localparam logic [REG_AW-1:0] RA_RBHI = 6'h1C;
    localparam logic [REG_AW-1:0] RA_GO   = 6'h25;

    localparam logic [BYTE_W-1:0] GO_KEY = 8'h01;

    typedef enum logic [2:0] {
        K_NONE,
        K_SEL,
        K_LO,
        K_HI,
        K_RBLO,
        K_RBHI,
        K_GO
    } reg_kind_e;

    typedef struct packed {
        logic [FIDX_W-1:0] idx;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } stage_t;

    typedef struct packed {
        logic              en;
        logic [FIDX_W-1:0] idx;
        logic [WORD_W-1:0] word;
    } commit_t;

    function automatic reg_kind_e decode_addr(input logic [REG_AW-1:0] a);
        reg_kind_e k;
        case (a)
            RA_SEL:  k = K_SEL;
            RA_LO:   k = K_LO;
            RA_HI:   k = K_HI;
            RA_RBLO: k = K_RBLO;
            RA_RBHI: k = K_RBHI;
            RA_GO:   k = K_GO;
            default: k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [WORD_W-1:0] join_bytes(input stage_t s);
        return {s.hi, s.lo};
    endfunction

endpackage

// File: rtl/ib16_stage.sv
module ib16_stage
    import ib16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_kind_e         kind,
    input  logic [BYTE_W-1:0] wdata,
    output stage_t            stage,
    output commit_t           cmt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else if (wr) begin
            case (kind)
                K_SEL:   stage.idx <= wdata[FIDX_W-1:0];
                K_LO:    stage.lo  <= wdata;
                K_HI:    stage.hi  <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        cmt.en   = wr && (kind == K_GO) && (wdata == GO_KEY);
        cmt.idx  = stage.idx;
        cmt.word = join_bytes(stage);
    end

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(stage)); // R3

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && kind == K_SEL) |=> (stage.idx == $past(wdata[FIDX_W-1:0]))); // R2

endmodule

// File: rtl/ib16_bank.sv
module ib16_bank
    import ib16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  commit_t           cmt,
    input  logic [FIDX_W-1:0] rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] mem [FDEPTH];

    for (genvar g = 0; g < FDEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (cmt.en && (cmt.idx == FIDX_W'(g))) begin
                mem[g] <= cmt.word;
            end
        end
    end

    assign rd_word = mem[rd_idx];

    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (rst)
        cmt.en |=> (mem[$past(cmt.idx)] == $past(cmt.word))); // R4

endmodule

// File: rtl/ib16_readback.sv
module ib16_readback
    import ib16_pkg::*;
(
    input  reg_kind_e         kind,
    input  stage_t            stage,
    input  logic [WORD_W-1:0] word,
    output logic [BYTE_W-1:0] rdata
);

    always_comb begin
        case (kind)
            K_SEL:   rdata = BYTE_W'(stage.idx);
            K_LO:    rdata = stage.lo;
            K_HI:    rdata = stage.hi;
            K_RBLO:  rdata = word[BYTE_W-1:0];
            K_RBHI:  rdata = word[WORD_W-1:BYTE_W];
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/ib16_bridge.sv
module ib16_bridge
    import ib16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata
);

    reg_kind_e         kind;
    stage_t            stage;
    commit_t           cmt;
    logic [WORD_W-1:0] bank_word;

    assign kind = decode_addr(reg_addr);

    ib16_stage u_stage (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .kind  (kind),
        .wdata (reg_wdata),
        .stage (stage),
        .cmt   (cmt)
    );

    ib16_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .cmt     (cmt),
        .rd_idx  (stage.idx),
        .rd_word (bank_word)
    );

    ib16_readback u_rb (
        .kind  (kind),
        .stage (stage),
        .word  (bank_word),
        .rdata (reg_rdata)
    );

    AST_BAD_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_GO && reg_wdata != GO_KEY) |=> $stable(bank_word)); // R5

    AST_COMMIT_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_GO && reg_wdata == GO_KEY)
            |=> (bank_word == $past({stage.hi, stage.lo}))); // R7

    AST_WIN_LO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_RBLO) |-> (reg_rdata == bank_word[BYTE_W-1:0])); // R6

    AST_WIN_HI: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_RBHI) |-> (reg_rdata == bank_word[WORD_W-1:BYTE_W])); // R6

endmodule

// File: tb/ib16_bridge_bench.sv
module ib16_bridge_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ib16_bridge u_ib16_bridge (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // vector: {write?, addr[5:0], data/expected[7:0], requirement number[7:0]}
    localparam int NV = 36;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 6'h18, 8'h02, 8'd2},
        {1'b1, 6'h19, 8'hF6, 8'd3},
        {1'b1, 6'h1A, 8'hC3, 8'd3},
        {1'b0, 6'h18, 8'h02, 8'd2},   // R2 index readback
        {1'b0, 6'h19, 8'hF6, 8'd3},   // R3 low staged
        {1'b0, 6'h1A, 8'hC3, 8'd3},   // R3 high staged
        {1'b0, 6'h1B, 8'h00, 8'd8},   // R8 no commit yet
        {1'b1, 6'h25, 8'h01, 8'd4},
        {1'b0, 6'h1B, 8'hF6, 8'd7},   // R7 visible right after commit
        {1'b0, 6'h1C, 8'hC3, 8'd4},   // R4 high half
        {1'b1, 6'h18, 8'h05, 8'd2},
        {1'b1, 6'h19, 8'h11, 8'd3},
        {1'b1, 6'h1A, 8'h22, 8'd3},
        {1'b1, 6'h25, 8'h02, 8'd5},
        {1'b0, 6'h1B, 8'h00, 8'd5},   // R5 bad key
        {1'b1, 6'h25, 8'h81, 8'd5},
        {1'b0, 6'h1C, 8'h00, 8'd5},   // R5 bad key
        {1'b1, 6'h25, 8'h01, 8'd4},
        {1'b0, 6'h1C, 8'h22, 8'd4},   // R4 second entry
        {1'b1, 6'h18, 8'h02, 8'd6},
        {1'b0, 6'h1B, 8'hF6, 8'd8},   // R8 first entry kept
        {1'b0, 6'h1C, 8'hC3, 8'd6},   // R6 index switch
        {1'b1, 6'h18, 8'hFF, 8'd2},
        {1'b1, 6'h19, 8'hAA, 8'd3},
        {1'b1, 6'h1A, 8'h55, 8'd3},
        {1'b1, 6'h25, 8'h01, 8'd4},
        {1'b0, 6'h1B, 8'hAA, 8'd4},   // R4 top index
        {1'b0, 6'h1C, 8'h55, 8'd4},
        {1'b1, 6'h1B, 8'h77, 8'd9},
        {1'b1, 6'h1C, 8'h77, 8'd9},
        {1'b0, 6'h1B, 8'hAA, 8'd9},   // R9 window write ignored
        {1'b1, 6'h10, 8'h33, 8'd9},
        {1'b0, 6'h10, 8'h00, 8'd9},   // R9 unmapped reads zero
        {1'b0, 6'h25, 8'h00, 8'd9},   // R9 trigger reads zero
        {1'b1, 6'h18, 8'h05, 8'd6},
        {1'b0, 6'h1B, 8'h11, 8'd6}    // R6 entry 5 low half
    };

    task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic chk_reg(input logic [5:0] a, input logic [7:0] exp, input int req);
        reg_addr = a;
        #1;
        n_checks++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL R%0d addr=%h actual=%h expected=%h", req, a, reg_rdata, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_reg(6'h18, 8'h00, 1);
        chk_reg(6'h19, 8'h00, 1);
        chk_reg(6'h1A, 8'h00, 1);
        chk_reg(6'h1B, 8'h00, 1);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][22])
                wr_reg(VEC[i][21:16], VEC[i][15:8]);
            else
                chk_reg(VEC[i][21:16], VEC[i][15:8], int'(VEC[i][7:0]));
        end

        // R7 overwrite then read in the very next cycle
        wr_reg(6'h18, 8'hFF);
        wr_reg(6'h19, 8'h3C);
        wr_reg(6'h1A, 8'h9E);
        @(negedge clk);
        reg_addr  = 6'h25;
        reg_wdata = 8'h01;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        chk_reg(6'h1C, 8'h9E, 7);
        chk_reg(6'h1B, 8'h3C, 7);

        // R1 reset clears staging and bank
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_reg(6'h18, 8'h00, 1);
        chk_reg(6'h1B, 8'h00, 1);
        wr_reg(6'h18, 8'hFF);
        chk_reg(6'h1C, 8'h00, 1);
        wr_reg(6'h18, 8'h05);
        chk_reg(6'h1B, 8'h00, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule